// File: doc/BRIEF.md
# Compare/Test Flag Unit with Branch Condition Check

This block computes the arithmetic status flags (zero, sign, carry, overflow) for compare and test operations on two 32-bit operands. A compare works like a subtraction and a test works like a bitwise AND. In both cases only the flags are kept, and the operands and any result are discarded. The flags sit in a register. Two direct commands also change that register: one clears carry and one complements carry.

A combinational evaluator reads the registered flags and a condition code. It reports whether a conditional branch on that condition would be taken. The conditions are equality, inequality, the two signed orderings and the two unsigned orderings. The execute stage drives an operation code with a write enable. The branch unit reads `taken_o` in the cycle after the flags update.

Top module: `flag_branch_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `flags_o` is 0 until the first write. The bit layout is [3]=overflow, [2]=carry, [1]=sign, [0]=zero.
- R2: With `we_i`=1 and `op_i`=1 (compare), the next clock edge loads the flags of `opa_i - opb_i`. Zero means the difference is 0. Sign is bit 31 of the difference. Carry is the borrow out of bit 31, which equals unsigned a<b. Overflow is set when the operand signs differ and the difference's sign differs from `opa_i`.
- R3: With `we_i`=1 and `op_i`=2 (test), the next edge sets zero and sign from `opa_i & opb_i` and clears carry and overflow.
- R4: With `we_i`=1 and `op_i`=3 (clear carry), the next edge forces carry to 0 and holds the other three flags.
- R5: With `we_i`=1 and `op_i`=4 (complement carry), the next edge inverts carry and holds the other three flags.
- R6: When `we_i`=0, or when `op_i` is 0 (none) or 5 to 7 (reserved), the flags keep their value at the edge.
- R7: `cond_i`=0 (equal) is taken when zero=1. `cond_i`=1 (not equal) is taken when zero=0.
- R8: `cond_i`=2 (signed greater) is taken when zero=0 and sign equals overflow. `cond_i`=3 (signed less) is taken when sign XOR overflow is 1.
- R9: `cond_i`=4 (unsigned above) is taken when carry=0 and zero=0. `cond_i`=5 (unsigned below) is taken when carry=1.
- R10: `cond_i`=6 and 7 are never taken. `taken_o` depends only on `cond_i` and the registered flags, and changes in the same cycle as `cond_i` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Flag write enable |
| op_i | input | 3 | Flag operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| cond_i | input | 3 | Branch condition code |
| flags_o | output | 4 | Registered flags {overflow, carry, sign, zero} |
| taken_o | output | 1 | Branch taken for `cond_i` |

## Verification
The clocked properties assume that `op_i`, `we_i` and both operands are stable around each rising edge. The bench only changes inputs on the falling edge, so that assumption holds. The properties also make no assumption about the order of operations, and may therefore see any mix of compare, test, carry commands, idle cycles and reserved codes. The random phase draws from all eight operation codes and all eight condition codes. It also steers part of the operands toward equal values and toward sign-boundary values, so that the overflow and equality paths fire often.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned COND_W = 3;

  typedef struct packed {
    logic ovf;
    logic cry;
    logic sgn;
    logic zro;
  } flags_t;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 3'd0,
    OP_CMP  = 3'd1,
    OP_TEST = 3'd2,
    OP_CLC  = 3'd3,
    OP_CMC  = 3'd4
  } flag_op_e;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 3'd0,
    CC_NE = 3'd1,
    CC_GT = 3'd2,
    CC_LT = 3'd3,
    CC_AB = 3'd4,
    CC_BL = 3'd5
  } cond_e;
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flag_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  flags_t           cur_i,
  output flags_t           nxt_o,
  output logic             upd_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0]   diff;
  logic [WIDTH-1:0] conj;

  assign diff = {1'b0, opa_i} - {1'b0, opb_i};
  assign conj = opa_i & opb_i;

  always_comb begin
    nxt_o = cur_i;
    upd_o = 1'b1;
    unique case (op_i)
      OP_CMP: begin
        nxt_o.zro = (diff[MSB:0] == '0);
        nxt_o.sgn = diff[MSB];
        nxt_o.cry = diff[WIDTH];
        nxt_o.ovf = (opa_i[MSB] ^ opb_i[MSB]) & (diff[MSB] ^ opa_i[MSB]);
      end
      OP_TEST: begin
        nxt_o.zro = (conj == '0);
        nxt_o.sgn = conj[MSB];
        nxt_o.cry = 1'b0;
        nxt_o.ovf = 1'b0;
      end
      OP_CLC:  nxt_o.cry = 1'b0;
      OP_CMC:  nxt_o.cry = ~cur_i.cry;
      default: upd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flag_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              taken_o
);
  logic lt_s;
  assign lt_s = flags_i.sgn ^ flags_i.ovf;

  always_comb begin
    unique case (cond_i)
      CC_EQ:   taken_o = flags_i.zro;
      CC_NE:   taken_o = ~flags_i.zro;
      CC_GT:   taken_o = ~flags_i.zro & ~lt_s;
      CC_LT:   taken_o = lt_s;
      CC_AB:   taken_o = ~flags_i.cry & ~flags_i.zro;
      CC_BL:   taken_o = flags_i.cry;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import flag_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WIDTH-1:0]  opa_i,
  input  logic [WIDTH-1:0]  opb_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [3:0]        flags_o,
  output logic              taken_o
);
  flags_t cur, nxt;
  logic   upd;

  flag_calc #(.WIDTH(WIDTH)) i_calc (
    .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
    .cur_i(cur), .nxt_o(nxt), .upd_o(upd)
  );

  flag_reg i_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(we_i & upd), .d_i(nxt), .q_o(cur)
  );

  cond_eval i_cond (.cond_i(cond_i), .flags_i(cur), .taken_o(taken_o));

  assign flags_o = cur;

  p_cmp_eq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_CMP && opa_i == opb_i) |=> flags_o[0]);
  p_cmp_borrow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_CMP) |=> flags_o[2] == $past(opa_i < opb_i));
  p_test_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_TEST) |=> flags_o[3:2] == 2'b00);
  p_clc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_CLC) |=> !flags_o[2] && $stable({flags_o[3], flags_o[1:0]}));
  p_cmc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_CMC) |=> flags_o[2] != $past(flags_o[2]));
  p_bad_cond_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i > 3'd5) |-> !taken_o);
endmodule

// File: tb/test_flag_branch_unit.sv
module test_flag_branch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [2:0]  cond = '0;
  logic [3:0]  flags;
  logic        taken;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit m_z = 0, m_s = 0, m_c = 0, m_o = 0;

  flag_branch_unit i_flag_branch_unit (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .op_i(op), .opa_i(a), .opb_i(b),
    .cond_i(cond), .flags_o(flags), .taken_o(taken)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_taken(int c);
    case (c)
      0: return m_z;
      1: return !m_z;
      2: return !m_z && (m_s == m_o);
      3: return m_s != m_o;
      4: return !m_c && !m_z;
      5: return m_c;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req);
    logic [3:0] exp_f;
    bit exp_t;
    exp_f = {m_o, m_c, m_s, m_z};
    exp_t = model_taken(int'(cond));
    n_cmp++;
    if (flags !== exp_f || taken !== exp_t) begin
      n_bad++;
      $display("FAIL %s: op=%0d cond=%0d a=%h b=%h flags=%b/%b taken=%b/%b (actual/expected)",
               req, op, cond, a, b, flags, exp_f, taken, exp_t);
    end
  endtask

  task automatic model_edge();
    longint sd;
    logic [32:0] d;
    logic [31:0] n;
    if (!we) return;
    case (op)
      1: begin
        d  = {1'b0, a} - {1'b0, b};
        sd = longint'($signed(a)) - longint'($signed(b));
        m_z = (a == b);
        m_s = d[31];
        m_c = (a < b);
        m_o = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
      end
      2: begin n = a & b; m_z = (n == 0); m_s = n[31]; m_c = 0; m_o = 0; end
      3: m_c = 0;
      4: m_c = !m_c;
      default: ;
    endcase
  endtask

  task automatic step(bit w, int o, logic [31:0] x, logic [31:0] y, int c, string req);
    @(negedge clk);
    we = w; op = 3'(o); a = x; b = y; cond = 3'(c);
    #1 check({req, "_pre"});
    @(posedge clk);
    model_edge();
    #1 check(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, MAX_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, y;
    #(CLK_PERIOD*2);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // R2 compares
    step(1, 1, 32'd5, 32'd5, 0, "R2_equal");
    step(1, 1, 32'd3, 32'd7, 5, "R2_below");
    step(1, 1, 32'h8000_0000, 32'd1, 2, "R2_ovf");
    step(1, 1, 32'h7fff_ffff, 32'hffff_ffff, 3, "R2_ovf_neg");
    step(1, 1, 32'hffff_fff0, 32'd1, 4, "R2_above");
    // R3 tests
    step(1, 2, 32'hf000_0000, 32'h8000_0001, 3, "R3_sign");
    step(1, 2, 32'h0000_00f0, 32'h0000_000f, 0, "R3_zero");
    // R4/R5 carry commands
    step(1, 1, 32'h8000_0000, 32'd9, 5, "R2_setup");
    step(1, 3, 32'd0, 32'd0, 5, "R4_clc");
    step(1, 4, 32'd0, 32'd0, 5, "R5_cmc");
    step(1, 4, 32'd0, 32'd0, 4, "R5_cmc2");
    // R6 holds
    step(0, 1, 32'd1, 32'd2, 1, "R6_we_low");
    step(1, 0, 32'd1, 32'd2, 2, "R6_none");
    step(1, 6, 32'd1, 32'd2, 3, "R6_reserved");
    // R7-R10 every condition against current flags
    for (int c = 0; c < 8; c++) step(0, 0, 0, 0, c, "R7_R8_R9_R10");
    for (int i = 0; i < 3000; i++) begin
      x = $urandom; y = $urandom;
      if (($urandom & 3) == 0) y = x;
      if (($urandom & 3) == 0) x = {~y[31], x[30:0]};
      step(($urandom & 7) != 0, int'($urandom % 8), x, y, int'($urandom % 8), "R2_R3_R4_R5_R6_random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule